// File: doc/BRIEF.md
# Peripheral Clock Mask Controller

This block holds a per-peripheral clock enable bit for every clocked peripheral. The bits sit in three 32-bit mask words: one for the high-speed system bus side and two for the peripheral bus side, split into a main domain and a backup domain. A simple APB-style slave port reads and writes the mask words. The same port also forwards accesses through a peripheral window, and each mask bit drives a glitch-free clock gate for its peripheral.

A peripheral whose peripheral-bus clock bit is cleared cannot be reached. An access to it returns zero with a slave error, and its select line is never raised. Two bits are special. One stands for the controller's own bus clock and the other for the bridge that carries it. Clearing either one locks the mask words against further writes, and only a system reset releases the lock. The lock state appears on a status output.

Top module: `clk_mask_ctrl`

## Requirements
- R1: After presetn is released, every implemented mask bit reads 1 (system-bus word 0x000000FF, main word 0x00000FFF, backup word 0x0000000F at default sizes), locked is 0 and every gated clock runs.
- R2: Writing 0 to a mask bit stops its gated clock, writing 1 restarts it, and a later read returns the written value.
- R3: Mask words sit at offset 0x000 (system-bus side, NA bits), 0x004 (main peripheral side, NM bits) and 0x008 (backup side, NB bits). Bits above a word's width read 0 and ignore writes. Any other offset below 0x800 reads 0 and a write to it changes nothing.
- R4: When paddr bit 11 is 1, the slot number is paddr[10:6]. Slots 0..NM-1 use the main bits and slots NM..NM+NB-1 use the backup bits. For an enabled slot, per_sel bit <slot> is high during setup and access, prdata equals per_rdata, pslverr is 0, and at most one per_sel bit is ever high.
- R5: An access to a slot whose bit is 0, or to a slot that does not exist, completes in one access cycle. It raises pslverr, returns prdata 0 and leaves per_sel all zero.
- R6: The system-bus bit k and the main peripheral bit k are independent: clearing one leaves the other's gated clock running.
- R7: Clearing main bit SELF_BIT (bit 3) raises locked one cycle after the write. From then on all mask writes are ignored and locked stays high until presetn is asserted.
- R8: Clearing system-bus bit BRIDGE_BIT (bit 0) locks the mask words in the same way as R7.
- R9: A gated clock changes its enable only while its source clock is low, so every high pulse is exactly one full high phase of the source.
- R10: pready is always 1, and accesses to mask-word offsets never raise pslverr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and main-domain source clock |
| presetn | input | 1 | Active-low system reset |
| bkp_clk | input | 1 | Backup-domain source clock |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write |
| paddr | input | ADDR_W | Byte address; bit ADDR_W-1 picks the peripheral window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data during the access phase |
| pready | output | 1 | Transfer done, always 1 |
| pslverr | output | 1 | Error for a refused peripheral access |
| per_sel | output | NM+NB | One select per peripheral slot |
| per_rdata | input | 32 | Read data returned by the selected peripheral |
| ahb_gclk | output | NA | Gated system-bus-side clocks |
| apb_gclk | output | NM | Gated main peripheral-side clocks |
| bkp_gclk | output | NB | Gated backup-domain clocks |
| locked | output | 1 | Mask words frozen until reset |

## Verification
The mask words are written with mixed patterns, such as 0x5B on the system-bus side and 0x0F0F on the main side, so that set and cleared bits alternate. This makes a bit-index mix-up or a shared system-bus/peripheral bit show up in the read data and in the gated clocks. Each of these patterns is written with all-ones upper bits. The peripheral window is then driven at enabled, masked, backup and nonexistent slots, which tells a wrong domain split or a missing range check apart from correct blocking. The two lockout causes are exercised one after the other, each followed by an attempted rewrite and a reset, so a lock that is not sticky, that misses one cause, or that survives reset gives a different read value.

// File: rtl/clk_mask_pkg.sv
`timescale 1ns/1ps
package clk_mask_pkg;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      SEL_SYS  = 2'd0,
      SEL_MAIN = 2'd1,
      SEL_BKP  = 2'd2,
      SEL_NONE = 2'd3
   } mask_word_e;

   function automatic logic [WORD_W-1:0] impl_bits(input int unsigned n);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < WORD_W; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/mask_regfile.sv
`timescale 1ns/1ps
module mask_regfile
   import clk_mask_pkg::*;
#(
   parameter int unsigned NA         = 8,
   parameter int unsigned NM         = 12,
   parameter int unsigned NB         = 4,
   parameter int unsigned SELF_BIT   = 3,
   parameter int unsigned BRIDGE_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  mask_word_e        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] sys_w,
   output logic [WORD_W-1:0] main_w,
   output logic [WORD_W-1:0] bkp_w,
   output logic              locked
);
   localparam logic [WORD_W-1:0] IMPL_S = impl_bits(NA);
   localparam logic [WORD_W-1:0] IMPL_M = impl_bits(NM);
   localparam logic [WORD_W-1:0] IMPL_B = impl_bits(NB);

   logic [WORD_W-1:0] sys_q, main_q, bkp_q;
   logic              lock_q;
   logic              wr_ok;

   assign wr_ok = wr_en && !lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_q  <= IMPL_S;
         main_q <= IMPL_M;
         bkp_q  <= IMPL_B;
         lock_q <= 1'b0;
      end else begin
         if (wr_ok) begin
            case (wr_sel)
               SEL_SYS:  sys_q  <= wr_data & IMPL_S;
               SEL_MAIN: main_q <= wr_data & IMPL_M;
               SEL_BKP:  bkp_q  <= wr_data & IMPL_B;
               default:  ;
            endcase
         end
         lock_q <= lock_q | ~main_q[SELF_BIT] | ~sys_q[BRIDGE_BIT];
      end
   end

   assign sys_w  = sys_q;
   assign main_w = main_q;
   assign bkp_w  = bkp_q;
   assign locked = lock_q;
endmodule

// File: rtl/access_guard.sv
`timescale 1ns/1ps
module access_guard
   import clk_mask_pkg::*;
#(
   parameter int unsigned NM         = 12,
   parameter int unsigned NB         = 4,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned SLOT_SHIFT = 6
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [WORD_W-1:0] sys_w,
   input  logic [WORD_W-1:0] main_w,
   input  logic [WORD_W-1:0] bkp_w,
   input  logic [WORD_W-1:0] per_rdata,
   output logic [WORD_W-1:0] prdata,
   output logic              pslverr,
   output logic [NM+NB-1:0]  per_sel,
   output logic              wr_en,
   output mask_word_e        wr_sel
);
   localparam int unsigned NP    = NM + NB;
   localparam int unsigned IDX_W = ADDR_W - 1 - SLOT_SHIFT;
   localparam int unsigned OFF_W = ADDR_W - 3;

   logic              win, access, slot_ok;
   logic [IDX_W-1:0]  slot;
   logic [NP-1:0]     slot_en, hit;
   logic [WORD_W-1:0] reg_word;

   assign win     = paddr[ADDR_W-1];
   assign slot    = paddr[SLOT_SHIFT +: IDX_W];
   assign slot_en = {bkp_w[NB-1:0], main_w[NM-1:0]};
   assign access  = psel && penable;

   for (genvar i = 0; i < NP; i++) begin : g_slot
      assign hit[i] = win && (slot == IDX_W'(i)) && slot_en[i];
   end

   assign slot_ok = |hit;
   assign per_sel = psel ? hit : '0;

   always_comb begin
      wr_sel = SEL_NONE;
      if (!win && paddr[1:0] == 2'b00) begin
         case (paddr[ADDR_W-2:2])
            OFF_W'(0): wr_sel = SEL_SYS;
            OFF_W'(1): wr_sel = SEL_MAIN;
            OFF_W'(2): wr_sel = SEL_BKP;
            default:   wr_sel = SEL_NONE;
         endcase
      end
   end

   always_comb begin
      case (wr_sel)
         SEL_SYS:  reg_word = sys_w;
         SEL_MAIN: reg_word = main_w;
         SEL_BKP:  reg_word = bkp_w;
         default:  reg_word = '0;
      endcase
   end

   always_comb begin
      prdata = '0;
      if (access) begin
         if (win) prdata = slot_ok ? per_rdata : '0;
         else     prdata = reg_word;
      end
   end

   assign pslverr = access && win && !slot_ok;
   assign wr_en   = access && pwrite && (wr_sel != SEL_NONE);
endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
   parameter int unsigned N     = 1,
   parameter int unsigned STYLE = 0
) (
   input  logic         clk_in,
   input  logic [N-1:0] en,
   output logic [N-1:0] gclk
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (STYLE == 0) begin : g_latch
         logic hold;
         always_latch begin
            if (!clk_in) hold = en[i];
         end
         assign gclk[i] = clk_in & hold;
      end else begin : g_negflop
         logic hold;
         always_ff @(negedge clk_in) hold <= en[i];
         assign gclk[i] = clk_in & hold;
      end
   end
endmodule

// File: rtl/clk_mask_ctrl.sv
`timescale 1ns/1ps
module clk_mask_ctrl
   import clk_mask_pkg::*;
#(
   parameter int unsigned NA         = 8,
   parameter int unsigned NM         = 12,
   parameter int unsigned NB         = 4,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned SLOT_SHIFT = 6,
   parameter int unsigned SELF_BIT   = 3,
   parameter int unsigned BRIDGE_BIT = 0,
   parameter int unsigned GATE_STYLE = 0
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              bkp_clk,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [NM+NB-1:0]  per_sel,
   input  logic [31:0]       per_rdata,
   output logic [NA-1:0]     ahb_gclk,
   output logic [NM-1:0]     apb_gclk,
   output logic [NB-1:0]     bkp_gclk,
   output logic              locked
);
   localparam int unsigned NP    = NM + NB;
   localparam int unsigned IDX_W = ADDR_W - 1 - SLOT_SHIFT;

   if (NA < 1 || NA > WORD_W) begin : g_bad_na
      $error("NA must lie in 1..32");
   end
   if (NM < 1 || NM > WORD_W) begin : g_bad_nm
      $error("NM must lie in 1..32");
   end
   if (NB < 1 || NB > WORD_W) begin : g_bad_nb
      $error("NB must lie in 1..32");
   end
   if (SELF_BIT >= NM || BRIDGE_BIT >= NA) begin : g_bad_lockbit
      $error("lockout bit index outside its word");
   end
   if (SLOT_SHIFT < 4 || SLOT_SHIFT + 2 > ADDR_W) begin : g_bad_shift
      $error("SLOT_SHIFT does not fit ADDR_W");
   end
   if (NP > (1 << IDX_W)) begin : g_bad_slots
      $error("peripheral window too small for NM+NB slots");
   end
   if (GATE_STYLE > 1) begin : g_bad_style
      $error("GATE_STYLE must be 0 or 1");
   end

   logic [WORD_W-1:0] ahb_w, main_w, bkp_w;
   logic              wr_en;
   mask_word_e        wr_sel;

   access_guard #(
      .NM(NM), .NB(NB), .ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT)
   ) u_guard (
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .sys_w(ahb_w), .main_w(main_w), .bkp_w(bkp_w),
      .per_rdata(per_rdata), .prdata(prdata), .pslverr(pslverr),
      .per_sel(per_sel), .wr_en(wr_en), .wr_sel(wr_sel)
   );

   mask_regfile #(
      .NA(NA), .NM(NM), .NB(NB), .SELF_BIT(SELF_BIT), .BRIDGE_BIT(BRIDGE_BIT)
   ) u_regs (
      .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(pwdata), .sys_w(ahb_w), .main_w(main_w), .bkp_w(bkp_w),
      .locked(locked)
   );

   clk_gate_bank #(.N(NA), .STYLE(GATE_STYLE)) u_gate_sys (
      .clk_in(pclk), .en(ahb_w[NA-1:0]), .gclk(ahb_gclk)
   );
   clk_gate_bank #(.N(NM), .STYLE(GATE_STYLE)) u_gate_main (
      .clk_in(pclk), .en(main_w[NM-1:0]), .gclk(apb_gclk)
   );
   clk_gate_bank #(.N(NB), .STYLE(GATE_STYLE)) u_gate_bkp (
      .clk_in(bkp_clk), .en(bkp_w[NB-1:0]), .gclk(bkp_gclk)
   );

   assign pready = 1'b1;
endmodule

// File: rtl/clk_mask_ctrl_chk.sv
`timescale 1ns/1ps
module clk_mask_ctrl_chk
   import clk_mask_pkg::*;
#(
   parameter int unsigned NA         = 8,
   parameter int unsigned NM         = 12,
   parameter int unsigned NB         = 4,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned SELF_BIT   = 3,
   parameter int unsigned BRIDGE_BIT = 0
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic [31:0]       prdata,
   input logic              pslverr,
   input logic [NM+NB-1:0]  per_sel,
   input logic              locked,
   input logic [WORD_W-1:0] ahb_w,
   input logic [WORD_W-1:0] main_w,
   input logic [WORD_W-1:0] bkp_w
);
   localparam logic [WORD_W-1:0] IMPL_S = impl_bits(NA);
   localparam logic [WORD_W-1:0] IMPL_M = impl_bits(NM);
   localparam logic [WORD_W-1:0] IMPL_B = impl_bits(NB);

   logic acc;
   assign acc = psel && penable;

   AST_RESET_DEFAULT: assert property (@(posedge pclk) disable iff (!presetn)
      !$past(presetn) |-> (ahb_w == IMPL_S && main_w == IMPL_M && bkp_w == IMPL_B && !locked)); // R1
   AST_WRITE_APPLIES: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && !locked && paddr == ADDR_W'(4)) |=> main_w == ($past(pwdata) & IMPL_M)); // R2
   AST_BLOCKED_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pslverr) |-> (prdata == '0 && per_sel == '0 && paddr[ADDR_W-1])); // R5
   AST_SEL_ONEHOT: assert property (@(posedge pclk) disable iff (!presetn)
      $onehot0(per_sel)); // R4
   AST_REG_NO_ERR: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !paddr[ADDR_W-1]) |-> !pslverr); // R10
   AST_LOCK_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
      locked |=> locked); // R7
   AST_LOCK_FREEZE: assert property (@(posedge pclk) disable iff (!presetn)
      locked |=> ($stable(ahb_w) && $stable(main_w) && $stable(bkp_w))); // R7
   AST_SELF_LOCKS: assert property (@(posedge pclk) disable iff (!presetn)
      !main_w[SELF_BIT] |=> locked); // R7
   AST_BRIDGE_LOCKS: assert property (@(posedge pclk) disable iff (!presetn)
      !ahb_w[BRIDGE_BIT] |=> locked); // R8
endmodule

bind clk_mask_ctrl clk_mask_ctrl_chk #(
   .NA(NA), .NM(NM), .NB(NB), .ADDR_W(ADDR_W),
   .SELF_BIT(SELF_BIT), .BRIDGE_BIT(BRIDGE_BIT)
) u_chk (
   .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
   .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
   .pslverr(pslverr), .per_sel(per_sel), .locked(locked),
   .ahb_w(ahb_w), .main_w(main_w), .bkp_w(bkp_w)
);

// File: tb/tb_clk_mask_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mask_ctrl;
   localparam int NA = 8, NM = 12, NB = 4, AW = 12, SELF = 3, BRIDGE = 0;
   localparam int NP = NM + NB;
   localparam logic [31:0] PER_DATA = 32'hC0DE_1234;

   logic pclk = 0, bkp_clk = 0, presetn = 0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [AW-1:0] paddr = '0;
   logic [31:0] pwdata = '0, per_rdata = PER_DATA;
   logic [31:0] prdata;
   logic pready, pslverr, locked;
   logic [NP-1:0] per_sel;
   logic [NA-1:0] ahb_gclk;
   logic [NM-1:0] apb_gclk;
   logic [NB-1:0] bkp_gclk;

   always #10 pclk = ~pclk;
   always #30 bkp_clk = ~bkp_clk;

   clk_mask_ctrl dut (
      .pclk(pclk), .presetn(presetn), .bkp_clk(bkp_clk), .psel(psel),
      .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .prdata(prdata), .pready(pready), .pslverr(pslverr), .per_sel(per_sel),
      .per_rdata(per_rdata), .ahb_gclk(ahb_gclk), .apb_gclk(apb_gclk),
      .bkp_gclk(bkp_gclk), .locked(locked)
   );

   int vectors = 0, fails = 0;
   logic [NA-1:0] r_ahb = '1;
   logic [NM-1:0] r_main = '1;
   logic [NB-1:0] r_bkp = '1;
   bit r_lock = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference lock model: a cleared self or bridge bit locks on the next edge
   always @(posedge pclk) begin
      if (!presetn) r_lock <= 0;
      else r_lock <= r_lock | ~r_main[SELF] | ~r_ahb[BRIDGE];
   end

   // every-clock comparison
   always @(negedge pclk) begin
      if (presetn) begin
         chk("R7", "locked", 32'(locked), 32'(r_lock));
         chk("R10", "pready", 32'(pready), 32'd1);
         if (!psel) chk("R4", "idle per_sel", 32'(per_sel), 32'd0);
      end
   end

   // pulse width monitors (R9)
   longint ra[NA], rm[NM], rb[NB];
   logic [NA-1:0] pa = '0;
   logic [NM-1:0] pm = '0;
   logic [NB-1:0] pb = '0;
   initial begin
      foreach (ra[i]) ra[i] = -1;
      foreach (rm[i]) rm[i] = -1;
      foreach (rb[i]) rb[i] = -1;
   end
   always @(ahb_gclk) begin
      for (int i = 0; i < NA; i++) begin
         if (ahb_gclk[i] && !pa[i]) ra[i] = $time;
         if (!ahb_gclk[i] && pa[i] && ra[i] >= 0) chk("R9", "sys pulse", 32'($time - ra[i]), 32'd10);
      end
      pa = ahb_gclk;
   end
   always @(apb_gclk) begin
      for (int i = 0; i < NM; i++) begin
         if (apb_gclk[i] && !pm[i]) rm[i] = $time;
         if (!apb_gclk[i] && pm[i] && rm[i] >= 0) chk("R9", "main pulse", 32'($time - rm[i]), 32'd10);
      end
      pm = apb_gclk;
   end
   always @(bkp_gclk) begin
      for (int i = 0; i < NB; i++) begin
         if (bkp_gclk[i] && !pb[i]) rb[i] = $time;
         if (!bkp_gclk[i] && pb[i] && rb[i] >= 0) chk("R9", "bkp pulse", 32'($time - rb[i]), 32'd30);
      end
      pb = bkp_gclk;
   end

   task automatic apply_reset();
      @(negedge pclk);
      presetn = 0;
      r_ahb = '1; r_main = '1; r_bkp = '1;
      repeat (3) @(negedge pclk);
      presetn = 1;
   endtask

   task automatic apb(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output bit err, output logic [NP-1:0] sel_s,
                      output logic [NP-1:0] sel_a);
      @(negedge pclk);
      psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
      #2 sel_s = per_sel;
      @(negedge pclk);
      penable = 1;
      #2 rd = prdata; err = pslverr; sel_a = per_sel;
      @(posedge pclk);
      #1;
      if (wr && !a[AW-1] && !r_lock) begin
         case (a)
            AW'(0): r_ahb  = wd[NA-1:0];
            AW'(4): r_main = wd[NM-1:0];
            AW'(8): r_bkp  = wd[NB-1:0];
            default: ;
         endcase
      end
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] wd);
      logic [31:0] rd; bit err; logic [NP-1:0] s1, s2;
      apb(1, a, wd, rd, err, s1, s2);
      chk("R10", "reg write err", 32'(err), 32'd0);
   endtask

   task automatic rd_reg(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] rd; bit err; logic [NP-1:0] s1, s2;
      apb(0, a, 32'h0, rd, err, s1, s2);
      chk(req, "reg read", rd, exp);
      chk("R10", "reg read err", 32'(err), 32'd0);
   endtask

   task automatic per_acc(input string req, input bit wr, input int slot, input bit ok);
      logic [31:0] rd; bit err; logic [NP-1:0] s1, s2;
      logic [NP-1:0] exp_sel;
      exp_sel = ok ? (NP'(1) << slot) : '0;
      apb(wr, AW'(12'h800 | (slot << 6)), 32'h1111_2222, rd, err, s1, s2);
      chk(req, "per_sel setup", 32'(s1), 32'(exp_sel));
      chk(req, "per_sel access", 32'(s2), 32'(exp_sel));
      chk(req, "pslverr", 32'(err), ok ? 32'd0 : 32'd1);
      if (!wr) chk(req, "per read", rd, ok ? PER_DATA : 32'd0);
   endtask

   task automatic check_gates(input string req);
      @(posedge pclk); #5;
      chk(req, "sys gclk high phase", 32'(ahb_gclk), 32'(r_ahb));
      chk(req, "main gclk high phase", 32'(apb_gclk), 32'(r_main));
      @(negedge pclk); #5;
      chk(req, "sys gclk low phase", 32'(ahb_gclk), 32'd0);
      @(posedge bkp_clk); #5;
      chk(req, "bkp gclk high phase", 32'(bkp_gclk), 32'(r_bkp));
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      apply_reset();
      // R1 defaults
      rd_reg("R1", AW'(0), 32'h0000_00FF);
      rd_reg("R1", AW'(4), 32'h0000_0FFF);
      rd_reg("R1", AW'(8), 32'h0000_000F);
      chk("R1", "locked after reset", 32'(locked), 32'd0);
      check_gates("R1");
      // R2/R3/R6 mixed patterns with upper bits set
      wr_reg(AW'(0), 32'hFFFF_FF5B);
      rd_reg("R3", AW'(0), 32'h0000_005B);
      wr_reg(AW'(4), 32'hFFFF_0F0F);
      rd_reg("R3", AW'(4), 32'h0000_0F0F);
      wr_reg(AW'(8), 32'hFFFF_FFF5);
      rd_reg("R3", AW'(8), 32'h0000_0005);
      check_gates("R2");
      chk("R6", "sys bit2 off", 32'(ahb_gclk[2] | pa[2]), 32'd0);
      check_gates("R6");
      // R4/R5 peripheral window
      per_acc("R4", 0, 0, 1);
      per_acc("R4", 1, 1, 1);
      per_acc("R5", 0, 4, 0);
      per_acc("R5", 1, 5, 0);
      per_acc("R4", 0, NM, 1);
      per_acc("R5", 0, NM + 1, 0);
      per_acc("R5", 0, 20, 0);
      // R3 unused offsets
      wr_reg(AW'(12), 32'hFFFF_FFFF);
      rd_reg("R3", AW'(12), 32'h0);
      rd_reg("R3", AW'(16), 32'h0);
      rd_reg("R3", AW'(4), 32'h0000_0F0F);
      // R2 restore
      wr_reg(AW'(0), 32'hFFFF_FFFF);
      wr_reg(AW'(4), 32'hFFFF_FFFF);
      wr_reg(AW'(8), 32'hFFFF_FFFF);
      rd_reg("R2", AW'(4), 32'h0000_0FFF);
      check_gates("R2");
      per_acc("R2", 0, 4, 1);
      // R7 self lockout
      wr_reg(AW'(4), 32'h0000_0FF7);
      @(negedge pclk);
      chk("R7", "locked after self clear", 32'(locked), 32'd1);
      wr_reg(AW'(0), 32'h0);
      rd_reg("R7", AW'(0), 32'h0000_00FF);
      wr_reg(AW'(4), 32'hFFFF_FFFF);
      rd_reg("R7", AW'(4), 32'h0000_0FF7);
      check_gates("R7");
      apply_reset();
      chk("R7", "locked after reset", 32'(locked), 32'd0);
      rd_reg("R7", AW'(4), 32'h0000_0FFF);
      // R8 bridge lockout
      wr_reg(AW'(0), 32'h0000_00FE);
      @(negedge pclk);
      chk("R8", "locked after bridge clear", 32'(locked), 32'd1);
      wr_reg(AW'(8), 32'h0);
      rd_reg("R8", AW'(8), 32'h0000_000F);
      apply_reset();
      chk("R8", "locked after reset", 32'(locked), 32'd0);
      rd_reg("R8", AW'(0), 32'h0000_00FF);
      repeat (4) @(negedge pclk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule